// File: doc/BRIEF.md
# Down-Counting Timer Bank with APB Access

This block holds a parameterised number of independent down-counters behind a zero-wait-state APB slave port. Each counter is as wide as the data bus (32 bits by default). While enabled, it decrements once per clock. When it is at zero, the next clock reloads it and raises that counter's interrupt flag. The reload source is chosen per counter: either the programmed load value, for periodic ticks, or all ones, for a free-running count that software turns into a rising timestamp by inverting the current value.

Each counter has five registers: load value, live count, control, acknowledge and masked status. A mask bit hides a counter's interrupt without stopping its count. Reading the acknowledge register clears the pending flag. Four shared registers give the masked flags of all counters, the raw flags of all counters, a clear-all acknowledge and a fixed version word. The bus clock also drives the counters.

Top module: `apb_cdtimer`

## Requirements
- R1: After reset every load value, count and control register reads zero, all raw flags are clear and every interrupt output is low.
- R2: Counter n occupies offsets n×0x14 + {0x00 load, 0x04 live count, 0x08 control, 0x0C acknowledge, 0x10 masked status}. Control bits are: bit 0 enable, bit 1 reload-from-load (1) or all-ones (0), bit 2 mask (1 hides the interrupt). Load and control read back as written.
- R3: A control write that sets enable while the counter is disabled copies the load value into the count on that write's clock edge.
- R4: While enabled and non-zero, the count drops by one on every clock, and the live count is readable at any time.
- R5: With bit 1 set, an enabled counter at zero reloads the load value on the next edge and sets its raw flag on that edge, so the interrupt rises load+1 clocks after the enabling edge.
- R6: With bit 1 clear, an enabled counter at zero reloads all ones instead of the load value.
- R7: With the mask set, the interrupt output stays low and the masked status (per-counter offset 0x10 bit 0, shared 0xA0 bit n) reads zero. The raw flag at 0xA8 bit n still sets, and counting goes on.
- R8: A disabled counter holds its count, and its interrupt output is low whatever its flag.
- R9: A read of a counter's acknowledge register returns zero and clears only that counter's raw flag.
- R10: A read of 0xA4 clears every counter's raw flag. 0xA0 and 0xA8 report masked and raw flags with counter n at bit n.
- R11: 0xAC returns the VERSION parameter, unmapped offsets read zero, PREADY is always 1 and PSLVERR is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data |
| pready_o | output | 1 | Always 1 |
| pslverr_o | output | 1 | Always 0 |
| irq_o | output | N_TMR | Per-counter interrupt: flag, not masked, enabled |

## Verification
The assertions assume that a write and an acknowledge read never reach the same counter in one cycle. They also assume that an enabling write reaches a counter only while it is disabled, so the load-on-enable rule is the only load path. The stimulus is a series of complete APB transfers, one at a time. The bench first clears enable and only then writes a new load value and enables again. It times every interrupt and count check from the enabling edge, so a wrap and an acknowledge never fall on the same edge.

// File: rtl/apb_cdtimer_pkg.sv
package apb_cdtimer_pkg;
  localparam int unsigned TMR_STRIDE = 'h14;
  localparam int unsigned OFF_LOAD   = 'h00;
  localparam int unsigned OFF_CUR    = 'h04;
  localparam int unsigned OFF_CTRL   = 'h08;
  localparam int unsigned OFF_ACK    = 'h0C;
  localparam int unsigned OFF_STAT   = 'h10;
  localparam int unsigned G_STAT     = 'hA0;
  localparam int unsigned G_ACK      = 'hA4;
  localparam int unsigned G_RAW      = 'hA8;
  localparam int unsigned G_VER      = 'hAC;
  localparam int unsigned MAX_TMR    = G_STAT / TMR_STRIDE;

  typedef struct packed {
    logic mask;
    logic reload;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/apb_cdtimer_dec.sv
module apb_cdtimer_dec
  import apb_cdtimer_pkg::*;
#(
  parameter int unsigned N_TMR  = 2,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_TMR-1:0]  load_sel_o,
  output logic [N_TMR-1:0]  cur_sel_o,
  output logic [N_TMR-1:0]  ctrl_sel_o,
  output logic [N_TMR-1:0]  ack_sel_o,
  output logic [N_TMR-1:0]  stat_sel_o,
  output logic              g_stat_o,
  output logic              g_ack_o,
  output logic              g_raw_o,
  output logic              g_ver_o
);
  for (genvar n = 0; n < N_TMR; n++) begin : g_tmr
    localparam int unsigned BASE = n * TMR_STRIDE;
    assign load_sel_o[n] = addr_i == ADDR_W'(BASE + OFF_LOAD);
    assign cur_sel_o[n]  = addr_i == ADDR_W'(BASE + OFF_CUR);
    assign ctrl_sel_o[n] = addr_i == ADDR_W'(BASE + OFF_CTRL);
    assign ack_sel_o[n]  = addr_i == ADDR_W'(BASE + OFF_ACK);
    assign stat_sel_o[n] = addr_i == ADDR_W'(BASE + OFF_STAT);
  end

  assign g_stat_o = addr_i == ADDR_W'(G_STAT);
  assign g_ack_o  = addr_i == ADDR_W'(G_ACK);
  assign g_raw_o  = addr_i == ADDR_W'(G_RAW);
  assign g_ver_o  = addr_i == ADDR_W'(G_VER);
endmodule

// File: rtl/apb_cdtimer_core.sv
module apb_cdtimer_core
  import apb_cdtimer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_we_i,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cnt_o,
  output ctrl_t             ctrl_o,
  output logic              raw_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] load_q, cnt_q;
  ctrl_t             ctrl_q;
  logic              raw_q;
  logic              en_rise, wrap;

  assign en_rise = ctrl_we_i & wdata_i[0] & ~ctrl_q.en;
  assign wrap    = ctrl_q.en & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (load_we_i) load_q <= wdata_i;
      if (ctrl_we_i) ctrl_q <= ctrl_t'(wdata_i[2:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (en_rise)    cnt_q <= load_q;
    else if (ctrl_q.en)  cnt_q <= wrap ? (ctrl_q.reload ? load_q : '1) : cnt_q - 1'b1;
  end

  // a wrap on the acknowledge edge wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     raw_q <= 1'b0;
    else if (wrap)   raw_q <= 1'b1;
    else if (ack_i)  raw_q <= 1'b0;
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign raw_o  = raw_q;
  assign irq_o  = raw_q & ~ctrl_q.mask & ctrl_q.en;

  p_enable_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise |=> cnt_q == $past(load_q));
  p_decrement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DATA_W'(1));
  p_reload_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && ctrl_q.reload) |=> cnt_q == $past(load_q));
  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> raw_q);
  p_reload_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !ctrl_q.reload) |=> &cnt_q);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !ctrl_we_i) |=> $stable(cnt_q));
  p_ack_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !wrap) |=> !raw_q);
endmodule

// File: rtl/apb_cdtimer.sv
module apb_cdtimer
  import apb_cdtimer_pkg::*;
#(
  parameter int unsigned N_TMR   = 2,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic [N_TMR-1:0]  irq_o
);
  localparam int unsigned FLAG_PAD = DATA_W - N_TMR;

  logic [N_TMR-1:0] load_sel, cur_sel, ctrl_sel, ack_sel, stat_sel;
  logic             g_stat, g_ack, g_raw, g_ver;
  logic             wr_acc, rd_acc;
  logic [DATA_W-1:0] load_w [N_TMR];
  logic [DATA_W-1:0] cnt_w  [N_TMR];
  ctrl_t             ctrl_w [N_TMR];
  logic [N_TMR-1:0]  raw_w, msk_w;
  logic [DATA_W-1:0] rdata;

  assign wr_acc = psel_i & penable_i & pwrite_i;
  assign rd_acc = psel_i & penable_i & ~pwrite_i;

  apb_cdtimer_dec #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) dec_i (
    .addr_i    (paddr_i),
    .load_sel_o(load_sel),
    .cur_sel_o (cur_sel),
    .ctrl_sel_o(ctrl_sel),
    .ack_sel_o (ack_sel),
    .stat_sel_o(stat_sel),
    .g_stat_o  (g_stat),
    .g_ack_o   (g_ack),
    .g_raw_o   (g_raw),
    .g_ver_o   (g_ver)
  );

  for (genvar n = 0; n < N_TMR; n++) begin : g_tmr
    logic irq_n;
    apb_cdtimer_core #(.DATA_W(DATA_W)) core_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_we_i(wr_acc & load_sel[n]),
      .ctrl_we_i(wr_acc & ctrl_sel[n]),
      .wdata_i  (pwdata_i),
      .ack_i    (rd_acc & (ack_sel[n] | g_ack)),
      .load_o   (load_w[n]),
      .cnt_o    (cnt_w[n]),
      .ctrl_o   (ctrl_w[n]),
      .raw_o    (raw_w[n]),
      .irq_o    (irq_n)
    );
    assign msk_w[n] = ctrl_w[n].mask;
    assign irq_o[n] = irq_n;
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < N_TMR; n++) begin
      if (load_sel[n]) rdata = load_w[n];
      if (cur_sel[n])  rdata = cnt_w[n];
      if (ctrl_sel[n]) rdata = {{(DATA_W-3){1'b0}}, ctrl_w[n]};
      if (stat_sel[n]) rdata = {{(DATA_W-1){1'b0}}, raw_w[n] & ~msk_w[n]};
    end
    if (g_stat) rdata = {{FLAG_PAD{1'b0}}, raw_w & ~msk_w};
    if (g_raw)  rdata = {{FLAG_PAD{1'b0}}, raw_w};
    if (g_ver)  rdata = DATA_W'(VERSION);
  end

  assign prdata_o  = (psel_i && !pwrite_i) ? rdata : '0;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  initial begin
    p_param_fit_r2: assert (N_TMR >= 1 && N_TMR <= MAX_TMR && DATA_W >= 32);
  end

  p_irq_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> raw_w[0] && !msk_w[0]);
  p_global_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && g_ack && !ctrl_w[0].en) |=> !raw_w[0]);
endmodule

// File: tb/apb_cdtimer_tb_top.sv
module apb_cdtimer_tb_top;
  localparam logic [31:0] VER = 32'hA5C3_0107;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [1:0]  irq;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  apb_cdtimer #(.N_TMR(2), .ADDR_W(8), .DATA_W(32), .VERSION(VER)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); chk("R1 load", d, 0);
    rd(8'h04, d); chk("R1 count", d, 0);
    rd(8'h08, d); chk("R1 ctrl", d, 0);
    rd(8'hA8, d); chk("R1 raw", d, 0);
    chk("R1 irq", {30'd0, irq}, 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(8'h14, 32'h1234_5678); rd(8'h14, d); chk("R2 load readback", d, 32'h1234_5678);
    wr(8'h1C, 32'h6); rd(8'h1C, d); chk("R2 ctrl readback", d, 32'h6);
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] d, d2;
    wr(8'h00, 32'd5);
    wr(8'h08, 32'h3);
    repeat (5) @(negedge clk);
    chk("R5 irq before wrap", {31'd0, irq[0]}, 0);
    @(negedge clk);
    chk("R5 irq at load+1", {31'd0, irq[0]}, 1);
    rd(8'h04, d); chk("R4 R5 count after reload", d, 32'd4);
    rd(8'h0C, d); chk("R9 ack data", d, 0);
    chk("R9 irq cleared", {31'd0, irq[0]}, 0);
    wr(8'h08, 32'h2);
    rd(8'h04, d); repeat (10) @(negedge clk); rd(8'h04, d2);
    chk("R8 count held", d2, d);
    chk("R8 irq low when disabled", {31'd0, irq[0]}, 0);
    rd(8'hA4, d); rd(8'hA8, d); chk("R10 clear all", d, 0);
  endtask

  task automatic t_free;
    logic [31:0] d;
    wr(8'h14, 32'd2);
    wr(8'h1C, 32'h1);
    repeat (2) @(negedge clk);
    chk("R6 irq before wrap", {31'd0, irq[1]}, 0);
    @(negedge clk);
    chk("R6 irq at wrap", {31'd0, irq[1]}, 1);
    rd(8'h18, d); chk("R6 all-ones reload", d, 32'hFFFF_FFFE);
    rd(8'h24, d); chk("R2 per-counter status", d, 1);
    rd(8'hA0, d); chk("R10 masked status bit1", d, 2);
    rd(8'hA8, d); chk("R10 raw status bit1", d, 2);
    rd(8'h20, d); chk("R9 ack counter1", {31'd0, irq[1]}, 0);
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(8'h00, 32'd3); wr(8'h08, 32'h7);
    wr(8'h14, 32'd3); wr(8'h1C, 32'h7);
    repeat (10) @(negedge clk);
    chk("R7 irq masked", {30'd0, irq}, 0);
    rd(8'h10, d); chk("R7 status masked", d, 0);
    rd(8'hA0, d); chk("R7 global masked", d, 0);
    rd(8'hA8, d); chk("R7 raw still sets", d, 3);
    wr(8'h08, 32'h4); wr(8'h1C, 32'h4);
    rd(8'hA8, d); chk("R8 flags kept while off", d, 3);
    rd(8'h20, d);
    rd(8'hA8, d); chk("R9 ack clears own only", d, 1);
    rd(8'hA4, d);
    rd(8'hA8, d); chk("R10 clear all", d, 0);
  endtask

  task automatic t_reenable;
    logic [31:0] d;
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h100);
    wr(8'h08, 32'h1);
    rd(8'h04, d); chk("R3 load on enable", d, 32'hFF);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_misc;
    logic [31:0] d;
    rd(8'hAC, d); chk("R11 version", d, VER);
    rd(8'h50, d); chk("R11 unmapped", d, 0);
    rd(8'h9C, d); chk("R11 unmapped high", d, 0);
    chk("R11 ready/err", {30'd0, pready, pslverr}, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_readback;
    t_periodic;
    t_free;
    t_mask;
    t_reenable;
    t_misc;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule